// File: doc/BRIEF.md
# Serial Programming Command and Data Slave

This block is the target-side front end of a two-wire serial programming port. A host toggles a slow programming clock and drives a data pin. The block samples both pins with its own fast system clock. It assembles six-bit command codes from them and, for commands that carry a word, follows with a sixteen-clock data segment. Decoded commands leave the block as a single-cycle strobe with the code beside it. Words from load commands are handed on with a load strobe. For read commands, the block fetches the word presented on its read input and shifts it back out through the data output, with a separate tristate enable.

A data segment wraps fourteen payload bits between a start clock and a stop clock. The pad driver must be enabled only between the rising edge of the second data clock and the rising edge of the sixteenth. Address counting, the memory array and analog timing checks belong to neighbouring logic.

Top module: `pgm_serial_slave`

## Requirements
- R1: A command is six programming-clock cycles. The data pin is sampled on each falling edge, and the first bit is the least significant. After the sixth falling edge, `cmd_strobe_o` pulses for one system cycle with the code on `cmd_code_o`.
- R2: Codes 0x00 and 0x02 are load commands, 0x04 is a read command, and 0x06, 0x08 and 0x0E take no data. Only load and read commands are followed by a data segment. After any other code, the next six clocks form a new command.
- R3: The values on the data pin during the first (start) and sixteenth (stop) clock of a data segment have no effect on the loaded word.
- R4: During a load segment, clocks 2 to 15 carry a 14-bit word with the least significant bit first. After the sixteenth falling edge, `load_strobe_o` pulses for one cycle with that word on `load_data_o`.
- R5: During a read segment, `pgm_dat_oe` goes high on the rising edge of data clock 2 and is low before that edge. It is never high outside a read segment.
- R6: During a read segment, `pgm_dat_oe` stays high through the falling edge of clock 15 and goes low on the rising edge of data clock 16.
- R7: `rd_word_i` is captured on the rising edge of data clock 2. Bit k is presented on `pgm_dat_o` from the rising edge of data clock k+2, so the host can sample it on the falling edge that follows. Later changes on `rd_word_i` have no effect on the segment.
- R8: A code outside the set in R2 pulses `illegal_cmd_o` together with `cmd_strobe_o` and takes no data segment.
- R9: `rst` (synchronous, active high) returns the block to command reception with the bit count cleared and the output enable low. A partly received command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the programming clock |
| rst | input | 1 | Synchronous active-high reset |
| pgm_clk_i | input | 1 | Programming clock pin, asynchronous |
| pgm_dat_i | input | 1 | Data pin input, asynchronous |
| rd_word_i | input | 14 | Word to return during a read segment |
| pgm_dat_o | output | 1 | Data pin output value |
| pgm_dat_oe | output | 1 | Data pin output enable |
| cmd_strobe_o | output | 1 | One-cycle pulse when a command completes |
| cmd_code_o | output | 6 | Last received command code |
| illegal_cmd_o | output | 1 | One-cycle pulse for an unknown code |
| load_strobe_o | output | 1 | One-cycle pulse when a load word is complete |
| load_data_o | output | 14 | Last loaded word |

## Verification
The hardest situation to reach from the ports is the edge of the output-enable window. The enable must switch on the rising edges of clocks 2 and 16 and must stay high across the falling edge of clock 15. The bench drives the programming clock in slow half-periods of several system cycles. It samples the enable and the data bit at the end of every high and every low phase, which shows which edge moved it. A second read changes the read word after clock 2, and a reset issued in the middle of a read checks that a truncated segment leaves the pad released and the command framing intact.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    localparam int CMD_W   = 6;
    localparam int DATA_W  = 14;
    localparam int SEG_CLK = DATA_W + 2;
    localparam int CNT_W   = $clog2(SEG_CLK);

    localparam logic [CMD_W-1:0] OP_LOAD_CFG  = 6'h00;
    localparam logic [CMD_W-1:0] OP_LOAD_WORD = 6'h02;
    localparam logic [CMD_W-1:0] OP_READ_WORD = 6'h04;
    localparam logic [CMD_W-1:0] OP_ADVANCE   = 6'h06;
    localparam logic [CMD_W-1:0] OP_PROGRAM   = 6'h08;
    localparam logic [CMD_W-1:0] OP_END_PROG  = 6'h0E;

    typedef enum logic {ST_CMD, ST_DATA} seq_st_e;
    typedef enum logic [1:0] {SEG_NONE, SEG_LOAD, SEG_READ, SEG_BAD} seg_kind_e;

    function automatic seg_kind_e classify(input logic [CMD_W-1:0] code);
        case (code)
            OP_LOAD_CFG, OP_LOAD_WORD:            return SEG_LOAD;
            OP_READ_WORD:                         return SEG_READ;
            OP_ADVANCE, OP_PROGRAM, OP_END_PROG:  return SEG_NONE;
            default:                              return SEG_BAD;
        endcase
    endfunction
endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            prev <= '0;
        end else begin
            s1   <= pin_i;
            s2   <= s1;
            prev <= s2;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign lvl_o[i]  = s2[i];
        assign rise_o[i] = s2[i] & ~prev[i];
        assign fall_o[i] = ~s2[i] & prev[i];
    end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
    import pgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              din_i,
    output logic              cmd_strobe_o,
    output logic [CMD_W-1:0]  cmd_code_o,
    output logic              illegal_o,
    output logic              load_strobe_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              in_read_o,
    output logic              rd_start_o,
    output logic              rd_shift_o,
    output logic              rd_end_o
);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] SEG_LAST = CNT_W'(SEG_CLK - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(SEG_CLK - 2);

    seq_st_e            st;
    seg_kind_e          kind;
    logic [CNT_W-1:0]   cnt;
    logic [CMD_W-1:0]   sh_cmd;
    logic [DATA_W-1:0]  sh_dat;
    logic [CMD_W-1:0]   cmd_next;
    seg_kind_e          kind_next;

    always_comb begin
        cmd_next  = {din_i, sh_cmd[CMD_W-1:1]};
        kind_next = classify(cmd_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_CMD;
            kind          <= SEG_NONE;
            cnt           <= '0;
            sh_cmd        <= '0;
            sh_dat        <= '0;
            cmd_strobe_o  <= 1'b0;
            cmd_code_o    <= '0;
            illegal_o     <= 1'b0;
            load_strobe_o <= 1'b0;
            load_data_o   <= '0;
        end else begin
            cmd_strobe_o  <= 1'b0;
            illegal_o     <= 1'b0;
            load_strobe_o <= 1'b0;
            if (fall_i) begin
                if (st == ST_CMD) begin
                    sh_cmd <= cmd_next;
                    if (cnt == CMD_LAST) begin
                        cnt          <= '0;
                        cmd_code_o   <= cmd_next;
                        cmd_strobe_o <= 1'b1;
                        illegal_o    <= (kind_next == SEG_BAD);
                        if (kind_next == SEG_LOAD || kind_next == SEG_READ) begin
                            st   <= ST_DATA;
                            kind <= kind_next;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    if (cnt != '0 && cnt <= PAY_LAST)
                        sh_dat <= {din_i, sh_dat[DATA_W-1:1]};
                    if (cnt == SEG_LAST) begin
                        st   <= ST_CMD;
                        kind <= SEG_NONE;
                        cnt  <= '0;
                        if (kind == SEG_LOAD) begin
                            load_strobe_o <= 1'b1;
                            load_data_o   <= sh_dat;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign in_read_o  = (st == ST_DATA) && (kind == SEG_READ);
    assign rd_start_o = in_read_o && rise_i && (cnt == CNT_W'(1));
    assign rd_shift_o = in_read_o && rise_i && (cnt >= CNT_W'(2)) && (cnt <= PAY_LAST);
    assign rd_end_o   = in_read_o && rise_i && (cnt == SEG_LAST);

    // R1
    cmd_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMD) |-> (cnt <= CMD_LAST));
    // R2
    seg_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (kind == SEG_LOAD || kind == SEG_READ));
    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> cmd_strobe_o);
    // R4
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_strobe_o |=> !load_strobe_o);
    // R4
    load_vs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(load_strobe_o && cmd_strobe_o));
endmodule

// File: rtl/pgm_tx.sv
module pgm_tx
    import pgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start_i,
    input  logic              rd_shift_i,
    input  logic              rd_end_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic              dat_o,
    output logic              oe_o
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            oe_o <= 1'b0;
        end else if (rd_start_i) begin
            sh   <= rd_word_i;
            oe_o <= 1'b1;
        end else if (rd_shift_i) begin
            sh <= {1'b0, sh[DATA_W-1:1]};
        end else if (rd_end_i) begin
            oe_o <= 1'b0;
        end
    end

    assign dat_o = sh[0];

    // R5
    oe_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_o) |-> $past(rd_start_i));
    // R7
    hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_o && !rd_shift_i && !rd_end_i && !rd_start_i) |=> $stable(dat_o));
endmodule

// File: rtl/pgm_serial_slave.sv
module pgm_serial_slave
    import pgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_clk_i,
    input  logic              pgm_dat_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic              pgm_dat_o,
    output logic              pgm_dat_oe,
    output logic              cmd_strobe_o,
    output logic [CMD_W-1:0]  cmd_code_o,
    output logic              illegal_cmd_o,
    output logic              load_strobe_o,
    output logic [DATA_W-1:0] load_data_o
);
    logic [1:0] lvl, rise, fall;
    logic       in_read, rd_start, rd_shift, rd_end;

    pgm_sync #(.W(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  ({pgm_dat_i, pgm_clk_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    pgm_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .rise_i        (rise[0]),
        .fall_i        (fall[0]),
        .din_i         (lvl[1]),
        .cmd_strobe_o  (cmd_strobe_o),
        .cmd_code_o    (cmd_code_o),
        .illegal_o     (illegal_cmd_o),
        .load_strobe_o (load_strobe_o),
        .load_data_o   (load_data_o),
        .in_read_o     (in_read),
        .rd_start_o    (rd_start),
        .rd_shift_o    (rd_shift),
        .rd_end_o      (rd_end)
    );

    pgm_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .rd_start_i (rd_start),
        .rd_shift_i (rd_shift),
        .rd_end_i   (rd_end),
        .rd_word_i  (rd_word_i),
        .dat_o      (pgm_dat_o),
        .oe_o       (pgm_dat_oe)
    );

    // R5
    oe_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        pgm_dat_oe |-> in_read);
    // R6
    oe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        rd_end |=> !pgm_dat_oe);
endmodule

// File: tb/pgm_serial_slave_tb.sv
module pgm_serial_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pclk = 1'b0;
    logic        pdat = 1'b0;
    logic [13:0] rd_word = '0;
    logic        dat_o, dat_oe, cmd_stb, ill, ld_stb;
    logic [5:0]  code;
    logic [13:0] ld_data;

    int checks = 0;
    int fails  = 0;
    int n_cmd = 0, n_ill = 0, n_ld = 0;
    logic [5:0]  last_code = '0;
    logic [13:0] last_ld = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgm_serial_slave u_dut (
        .clk(clk), .rst(rst), .pgm_clk_i(pclk), .pgm_dat_i(pdat),
        .rd_word_i(rd_word), .pgm_dat_o(dat_o), .pgm_dat_oe(dat_oe),
        .cmd_strobe_o(cmd_stb), .cmd_code_o(code), .illegal_cmd_o(ill),
        .load_strobe_o(ld_stb), .load_data_o(ld_data)
    );

    always @(posedge clk) begin
        if (cmd_stb) begin n_cmd <= n_cmd + 1; last_code <= code; end
        if (ill)     n_ill <= n_ill + 1;
        if (ld_stb)  begin n_ld <= n_ld + 1; last_ld <= ld_data; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input bit d, output bit oe_hi, output bit dat_hi, output bit oe_lo);
        pdat = d;
        wait_cyc(HALF);
        pclk = 1'b1;
        wait_cyc(HALF);
        oe_hi = dat_oe;
        dat_hi = dat_o;
        pclk = 1'b0;
        wait_cyc(HALF);
        oe_lo = dat_oe;
    endtask

    task automatic send_cmd(input logic [5:0] c);
        bit a, b, e;
        for (int i = 0; i < 6; i++) tick(c[i], a, b, e);
    endtask

    task automatic send_load(input logic [13:0] w, input bit st, input bit sp, output int oe_seen);
        bit a, b, e;
        oe_seen = 0;
        tick(st, a, b, e); oe_seen += a + e;
        for (int i = 0; i < 14; i++) begin tick(w[i], a, b, e); oe_seen += a + e; end
        tick(sp, a, b, e); oe_seen += a + e;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(dat_oe == 0, "R9 oe after reset", dat_oe, 0);
        chk(cmd_stb == 0 && ld_stb == 0 && ill == 0, "R9 strobes after reset",
            {cmd_stb, ld_stb, ill}, 0);
    endtask

    task automatic t_nodata();
        int c0 = n_cmd;
        send_cmd(6'h06);
        chk(n_cmd == c0 + 1 && last_code == 6'h06, "R1 code 0x06", last_code, 6'h06);
        send_cmd(6'h08);
        chk(n_cmd == c0 + 2 && last_code == 6'h08, "R2 no segment after 0x06", last_code, 6'h08);
        send_cmd(6'h0E);
        chk(last_code == 6'h0E && n_ill == 0, "R2 code 0x0E legal", n_ill, 0);
    endtask

    task automatic t_load();
        int oe_cnt;
        int l0 = n_ld;
        send_cmd(6'h02);
        chk(last_code == 6'h02, "R1 load code", last_code, 6'h02);
        send_load(14'h2A5C, 1'b1, 1'b1, oe_cnt);
        chk(n_ld == l0 + 1, "R4 load strobe count", n_ld - l0, 1);
        chk(last_ld == 14'h2A5C, "R4 load word", last_ld, 14'h2A5C);
        chk(oe_cnt == 0, "R5 oe low in load", oe_cnt, 0);
        send_cmd(6'h00);
        send_load(14'h2A5C, 1'b0, 1'b0, oe_cnt);
        chk(last_ld == 14'h2A5C, "R3 start/stop ignored", last_ld, 14'h2A5C);
        send_cmd(6'h00);
        send_load(14'h0001, 1'b1, 1'b0, oe_cnt);
        chk(last_ld == 14'h0001, "R4 lsb first", last_ld, 14'h0001);
        send_cmd(6'h06);
        chk(last_code == 6'h06 && n_ld == l0 + 3, "R2 framing after load", last_code, 6'h06);
    endtask

    task automatic t_read(input logic [13:0] w, input bit change);
        bit oh [16]; bit dh [16]; bit ol [16];
        bit a, b, e;
        rd_word = w;
        send_cmd(6'h04);
        chk(last_code == 6'h04, "R1 read code", last_code, 6'h04);
        for (int k = 0; k < 16; k++) begin
            tick(1'b0, a, b, e);
            oh[k] = a; dh[k] = b; ol[k] = e;
            if (change && k == 1) rd_word = ~w;
        end
        chk(oh[0] == 0 && ol[0] == 0, "R5 oe low on clock 1", {oh[0], ol[0]}, 0);
        chk(oh[1] == 1, "R5 oe high at clock 2 rise", oh[1], 1);
        chk(ol[14] == 1, "R6 oe held past clock 15 fall", ol[14], 1);
        chk(oh[15] == 0, "R6 oe low at clock 16 rise", oh[15], 0);
        for (int k = 1; k < 15; k++) begin
            chk(oh[k] == 1 && dh[k] == w[k-1], "R7 read bit", dh[k], w[k-1]);
        end
        send_cmd(6'h06);
        chk(last_code == 6'h06, "R2 framing after read", last_code, 6'h06);
        rd_word = '0;
    endtask

    task automatic t_illegal();
        int i0 = n_ill;
        int c0 = n_cmd;
        send_cmd(6'h3F);
        chk(n_ill == i0 + 1 && n_cmd == c0 + 1, "R8 illegal flagged", n_ill - i0, 1);
        send_cmd(6'h06);
        chk(last_code == 6'h06 && n_ill == i0 + 1, "R8 no segment after illegal", last_code, 6'h06);
        send_cmd(6'h01);
        chk(n_ill == i0 + 2, "R8 code 0x01 illegal", n_ill - i0, 2);
    endtask

    task automatic t_reset_mid();
        bit a, b, e;
        tick(1'b1, a, b, e); tick(1'b1, a, b, e); tick(1'b1, a, b, e);
        do_reset();
        send_cmd(6'h08);
        chk(last_code == 6'h08, "R9 partial command dropped", last_code, 6'h08);
        rd_word = 14'h3FFF;
        send_cmd(6'h04);
        for (int k = 0; k < 5; k++) tick(1'b0, a, b, e);
        chk(dat_oe == 1, "R5 oe high mid read", dat_oe, 1);
        do_reset();
        chk(dat_oe == 0, "R9 reset releases pad", dat_oe, 0);
        send_cmd(6'h0E);
        chk(last_code == 6'h0E, "R9 framing after reset in read", last_code, 6'h0E);
    endtask

    initial begin
        t_reset_state();
        t_nodata();
        t_load();
        t_read(14'h3A96, 1'b0);
        t_read(14'h1563, 1'b1);
        t_illegal();
        t_reset_mid();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule